// File: doc/BRIEF.md
# Availability Mode State Controller

This block keeps track of the operating mode of a multiprocessor on-chip network. Each clock cycle it takes single-cycle event flags and a count of processors that are currently blocked. The event flags are a hardware fault, a detected software fault, a recovery, and a completed software correction. From these it decides the next mode. It presents the current mode as a 3-bit code and pulses a one-cycle strobe whenever that code changes.

The controller has three operational levels: full, reduced and minimal. It also has an out-of-service mode and a separate software-fault mode. The software-fault mode can be entered from any operational level. When that happens, the controller records the level it left. When the correction event arrives, it returns to exactly that level. The recorded level is also available as an output, so that the surrounding test logic can tell which mode-specific checks to resume.

Top module: `avail_mode_ctrl`

## Requirements
- R1: During reset and in the first cycle after it, the mode output is full operation (code 0), the change strobe is low and the recorded pre-fault mode is code 0.
- R2: Modes are 3-bit codes: full = 0, reduced = 1, minimal = 2, out-of-service = 3, software-fault = 4. No other code ever appears.
- R3: A hardware fault event steps the mode down one level: full to reduced, reduced to minimal, minimal to out-of-service. The new mode is visible one cycle after the event.
- R4: A software fault event in full, reduced or minimal mode moves the controller to software-fault mode (4) and records the mode it left.
- R5: A correction event in software-fault mode returns the controller to the recorded mode. A correction event in any other mode has no effect.
- R6: A recovery event in reduced, minimal or out-of-service mode returns the controller to full operation. It has no effect in full or software-fault mode.
- R7: When the blocked-processor count is greater than one (BLOCK_LIMIT), the controller goes to out-of-service mode from any mode. This overrides every event in that cycle, including recovery. A count of exactly one has no effect.
- R8: When events coincide in an operational mode, a software fault wins over a hardware fault, and a hardware fault wins over recovery.
- R9: In software-fault mode, hardware fault, software fault and recovery events are ignored. In out-of-service mode, hardware and software fault events are ignored.
- R10: The change strobe is high for exactly the one cycle in which the mode output first shows a new code. It is low otherwise.
- R11: The recorded pre-fault mode changes only on entry into software-fault mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_fault_i | input | 1 | Hardware fault event, one cycle |
| sw_fault_i | input | 1 | Software fault detected, one cycle |
| recover_i | input | 1 | Recovery event, one cycle |
| sw_fixed_i | input | 1 | Software correction completed, one cycle |
| blocked_cnt_i | input | CNT_W | Number of processors currently blocked |
| mode_o | output | 3 | Current mode code |
| mode_chg_o | output | 1 | One-cycle strobe on each mode change |
| saved_mode_o | output | 3 | Operational mode recorded on entry to software-fault mode |

## Verification
All state is visible at the ports. A wrong mode register appears on `mode_o` in the cycle after the offending event. The one-cycle strobe then flags that a change happened, or that one is missing. A corrupted pre-fault record is harder to see. It stays hidden on `saved_mode_o` until the correction event, when the controller returns to the wrong level. For that reason, the stimulus makes round trips through software-fault mode from more than one operational level, and it checks the return one cycle after each correction.

// File: rtl/avail_mode_pkg.sv
package avail_mode_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_FULL  = 3'd0,
        MODE_RED   = 3'd1,
        MODE_MIN   = 3'd2,
        MODE_DOWN  = 3'd3,
        MODE_SWF   = 3'd4
    } mode_e;

    typedef struct packed {
        logic shutdown;
        logic sw_fault;
        logic hw_fault;
        logic recover;
        logic sw_fixed;
    } evt_t;

    function automatic logic is_operational(mode_e m);
        return (m == MODE_FULL) || (m == MODE_RED) || (m == MODE_MIN);
    endfunction

    // one level down per hardware fault
    function automatic mode_e hw_step(mode_e m);
        case (m)
            MODE_FULL: return MODE_RED;
            MODE_RED:  return MODE_MIN;
            default:   return MODE_DOWN;
        endcase
    endfunction

endpackage

// File: rtl/avail_block_detect.sv
module avail_block_detect #(
    parameter int CNT_W = 3,
    parameter int LIMIT = 1
) (
    input  logic [CNT_W-1:0] blocked_cnt,
    output logic             shutdown
);
    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(LIMIT);

    always_comb shutdown = (blocked_cnt > LIMIT_V);
endmodule

// File: rtl/avail_mode_next.sv
module avail_mode_next
    import avail_mode_pkg::*;
(
    input  mode_e cur,
    input  mode_e saved,
    input  evt_t  evt,
    output mode_e nxt,
    output logic  capture
);
    always_comb begin
        nxt     = cur;
        capture = 1'b0;
        if (evt.shutdown) begin
            nxt = MODE_DOWN;
        end else begin
            case (cur)
                MODE_FULL, MODE_RED, MODE_MIN: begin
                    if (evt.sw_fault) begin
                        nxt     = MODE_SWF;
                        capture = 1'b1;
                    end else if (evt.hw_fault) begin
                        nxt = hw_step(cur);
                    end else if (evt.recover && cur != MODE_FULL) begin
                        nxt = MODE_FULL;
                    end
                end
                MODE_DOWN: begin
                    if (evt.recover) nxt = MODE_FULL;
                end
                MODE_SWF: begin
                    if (evt.sw_fixed) nxt = saved;
                end
                default: nxt = MODE_DOWN;
            endcase
        end
    end
endmodule

// File: rtl/avail_mode_regs.sv
module avail_mode_regs
    import avail_mode_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  mode_e nxt,
    input  logic  capture,
    output mode_e cur,
    output mode_e saved,
    output logic  chg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur   <= MODE_FULL;
            saved <= MODE_FULL;
            chg   <= 1'b0;
        end else begin
            cur <= nxt;
            chg <= (nxt != cur);
            if (capture) saved <= cur;
        end
    end
endmodule

// File: rtl/avail_mode_ctrl.sv
module avail_mode_ctrl
    import avail_mode_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int BLOCK_LIMIT = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hw_fault_i,
    input  logic              sw_fault_i,
    input  logic              recover_i,
    input  logic              sw_fixed_i,
    input  logic [CNT_W-1:0]  blocked_cnt_i,
    output logic [MODE_W-1:0] mode_o,
    output logic              mode_chg_o,
    output logic [MODE_W-1:0] saved_mode_o
);
    logic  shutdown;
    evt_t  evt;
    mode_e cur, saved, nxt;
    logic  capture, chg;

    avail_block_detect #(.CNT_W(CNT_W), .LIMIT(BLOCK_LIMIT)) u_blk (
        .blocked_cnt (blocked_cnt_i),
        .shutdown    (shutdown)
    );

    always_comb begin
        evt.shutdown = shutdown;
        evt.sw_fault = sw_fault_i;
        evt.hw_fault = hw_fault_i;
        evt.recover  = recover_i;
        evt.sw_fixed = sw_fixed_i;
    end

    avail_mode_next u_next (
        .cur     (cur),
        .saved   (saved),
        .evt     (evt),
        .nxt     (nxt),
        .capture (capture)
    );

    avail_mode_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .nxt     (nxt),
        .capture (capture),
        .cur     (cur),
        .saved   (saved),
        .chg     (chg)
    );

    assign mode_o       = cur;
    assign saved_mode_o = saved;
    assign mode_chg_o   = chg;
endmodule

// File: rtl/avail_mode_ctrl_chk.sv
module avail_mode_ctrl_chk #(
    parameter int CNT_W = 3,
    parameter int LIMIT = 1
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_fault_i,
    input logic             sw_fault_i,
    input logic             recover_i,
    input logic             sw_fixed_i,
    input logic [CNT_W-1:0] blocked_cnt_i,
    input logic [2:0]       mode_o,
    input logic             mode_chg_o,
    input logic [2:0]       saved_mode_o
);
    logic past_valid;
    always_ff @(posedge clk) past_valid <= !rst;

    logic shut;
    assign shut = (blocked_cnt_i > CNT_W'(LIMIT));

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (mode_o == 3'd0 && !mode_chg_o && saved_mode_o == 3'd0));

    assert_legal_code_R2: assert property (@(posedge clk) disable iff (rst || !past_valid)
        mode_o <= 3'd4);

    assert_hw_step_R3: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (mode_o == 3'd0 && hw_fault_i && !sw_fault_i && !shut) |=> (mode_o == 3'd1));

    assert_sw_entry_R4: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (mode_o <= 3'd2 && sw_fault_i && !shut) |=>
        (mode_o == 3'd4 && saved_mode_o == $past(mode_o)));

    assert_fix_return_R5: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (mode_o == 3'd4 && sw_fixed_i && !shut) |=> (mode_o == $past(saved_mode_o)));

    assert_shutdown_R7: assert property (@(posedge clk) disable iff (rst || !past_valid)
        shut |=> (mode_o == 3'd3));

    assert_strobe_R10: assert property (@(posedge clk) disable iff (rst || !past_valid)
        mode_chg_o == (mode_o != $past(mode_o)));

    assert_saved_hold_R11: assert property (@(posedge clk) disable iff (rst || !past_valid)
        (saved_mode_o != $past(saved_mode_o)) |-> (mode_o == 3'd4 && $past(mode_o) != 3'd4));
endmodule

bind avail_mode_ctrl avail_mode_ctrl_chk #(.CNT_W(CNT_W), .LIMIT(BLOCK_LIMIT)) u_chk (.*);

// File: tb/avail_mode_ctrl_tb.sv
`timescale 1ns/1ps
module avail_mode_ctrl_tb;
    localparam int CNT_W = 3;
    localparam int NV    = 26;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             hw = 1'b0, sw = 1'b0, rec = 1'b0, fix = 1'b0;
    logic [CNT_W-1:0] blk = '0;
    logic [2:0]       mode, saved;
    logic             chg;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    avail_mode_ctrl #(.CNT_W(CNT_W), .BLOCK_LIMIT(1)) u_dut (
        .clk (clk), .rst (rst),
        .hw_fault_i (hw), .sw_fault_i (sw), .recover_i (rec), .sw_fixed_i (fix),
        .blocked_cnt_i (blk),
        .mode_o (mode), .mode_chg_o (chg), .saved_mode_o (saved)
    );

    // {hw,sw,rec,fix}, blocked, expected mode, expected strobe, expected saved
    localparam logic [13:0] VEC [NV] = '{
        {4'b0000, 3'd0, 3'd0, 1'b0, 3'd0},
        {4'b1000, 3'd0, 3'd1, 1'b1, 3'd0},
        {4'b0000, 3'd0, 3'd1, 1'b0, 3'd0},
        {4'b1000, 3'd0, 3'd2, 1'b1, 3'd0},
        {4'b0100, 3'd0, 3'd4, 1'b1, 3'd2},
        {4'b1000, 3'd0, 3'd4, 1'b0, 3'd2},
        {4'b0010, 3'd0, 3'd4, 1'b0, 3'd2},
        {4'b0001, 3'd0, 3'd2, 1'b1, 3'd2},
        {4'b0001, 3'd0, 3'd2, 1'b0, 3'd2},
        {4'b0010, 3'd0, 3'd0, 1'b1, 3'd2},
        {4'b0010, 3'd0, 3'd0, 1'b0, 3'd2},
        {4'b1110, 3'd0, 3'd4, 1'b1, 3'd0},
        {4'b0001, 3'd0, 3'd0, 1'b1, 3'd0},
        {4'b1010, 3'd0, 3'd1, 1'b1, 3'd0},
        {4'b0100, 3'd2, 3'd3, 1'b1, 3'd0},
        {4'b0010, 3'd2, 3'd3, 1'b0, 3'd0},
        {4'b0100, 3'd0, 3'd3, 1'b0, 3'd0},
        {4'b1000, 3'd0, 3'd3, 1'b0, 3'd0},
        {4'b0010, 3'd0, 3'd0, 1'b1, 3'd0},
        {4'b1000, 3'd0, 3'd1, 1'b1, 3'd0},
        {4'b1000, 3'd0, 3'd2, 1'b1, 3'd0},
        {4'b1000, 3'd0, 3'd3, 1'b1, 3'd0},
        {4'b0010, 3'd0, 3'd0, 1'b1, 3'd0},
        {4'b0000, 3'd1, 3'd0, 1'b0, 3'd0},
        {4'b0100, 3'd0, 3'd4, 1'b1, 3'd0},
        {4'b0001, 3'd3, 3'd3, 1'b1, 3'd0}
    };

    string TAG [NV] = '{
        "R1", "R3", "R10", "R3", "R4", "R9", "R9", "R5", "R5", "R6",
        "R6", "R8", "R5", "R8", "R7", "R7", "R9", "R9", "R6", "R3",
        "R3", "R3", "R6", "R7", "R11", "R7"
    };

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1", "mode in reset", int'(mode), 0);
        check("R1", "strobe in reset", int'(chg), 0);
        check("R1", "saved in reset", int'(saved), 0);
        @(negedge clk) rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {hw, sw, rec, fix} = VEC[i][13:10];
            blk = VEC[i][9:7];
            @(posedge clk);
            #1;
            check(TAG[i], "mode", int'(mode), int'(VEC[i][6:4]));
            check(TAG[i], "strobe R10", int'(chg), int'(VEC[i][3]));
            check(TAG[i], "saved R11", int'(saved), int'(VEC[i][2:0]));
        end

        // strobe drops after one cycle once events stop (R10)
        @(negedge clk);
        {hw, sw, rec, fix} = 4'b0000;
        blk = '0;
        @(posedge clk); #1;
        check("R10", "strobe after idle", int'(chg), 0);
        check("R7", "down held while idle", int'(mode), 3);

        // move to minimal, enter software fault, then reset mid-run (R1)
        @(negedge clk) rec = 1'b1;
        @(negedge clk) begin rec = 1'b0; hw = 1'b1; end
        @(negedge clk);
        @(negedge clk) begin hw = 1'b0; sw = 1'b1; end
        @(negedge clk) sw = 1'b0;
        #1;
        check("R4", "saved from minimal", int'(saved), 2);
        check("R4", "mode after sw fault", int'(mode), 4);
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1", "mode after mid reset", int'(mode), 0);
        check("R1", "saved after mid reset", int'(saved), 0);
        check("R1", "strobe after mid reset", int'(chg), 0);
        @(negedge clk) rst = 1'b0;
        @(posedge clk); #1;
        check("R2", "idle after reset", int'(mode), 0);

        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end
endmodule